// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

This block is a 4-bit twisted-ring counter. Each enabled clock shifts the state one place from stage 0 toward stage 3. Stage 0 takes the complement of stage 3, so the counter walks through 8 states. The 8 states are thermometer patterns of ones and zeros. Control logic can decode them with a single two-input gate per step.

A 4-bit register holds 16 patterns, and only 8 of them lie on the counting cycle. A disturbance can leave the register in one of the other 8, and a plain twisted ring then circulates there forever. This block fixes every pattern so that it drains back into the proper cycle. A parameter picks the repair scheme. One scheme rewrites the serial input equation. The other loads a fixed pattern when a two-bit match is seen.

Reset is synchronous and active low. It loads a parameterised pattern, which is `0000` by default. When the enable input is low, the state holds.

Top module: `jc_selfcorr_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cnt_q` takes the value of parameter `RST_STATE` (default `4'b0000`) on that edge, whatever `cnt_en` is.
- R2: With `cnt_en` high, a state on the proper cycle advances along it. In `cnt_q` (bit 0 = first stage, bit 3 = last stage) the order is 0000 → 0001 → 0011 → 0111 → 1111 → 1110 → 1100 → 1000 → 0000.
- R3: With `cnt_en` low and `rst_n` high, `cnt_q` keeps its value across the clock edge, including in off-cycle patterns.
- R4: With `FIX_MODE = FIX_FEEDBACK` and `cnt_en` high, every state shifts up one bit. The new bit 0 is `~q[3] | (~q[2] & q[1])`.
- R5: With `FIX_MODE = FIX_LOAD` and `cnt_en` high, a state with `q[3] == 0` and `q[0] == 0` is replaced by `4'b0001`.
- R6: With `FIX_MODE = FIX_LOAD` and `cnt_en` high, any other state shifts up one bit, and the new bit 0 is `~q[3]`.
- R7: Starting from any of the 16 patterns, under either scheme, the state lies on the R2 cycle after at most 8 enabled clocks. Once there, it never leaves the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Advance enable; low holds the state |
| cnt_q | output | 4 | Counter state, bit 0 = first stage |

## Verification
The off-cycle patterns are the hard case to reach. From reset and the clock alone, a correct counter never enters them, so no sequence on the three inputs can produce them. The bench therefore builds one instance for each scheme and each of the 16 patterns, with that pattern given as its reset value. It releases them all together and then drives a shared seeded random enable, holding the enable low for a stretch first. This exercises every repair path and the hold behaviour of every stray pattern. It also measures each recovery length against the 8-clock limit.

// File: rtl/jc_pkg.sv
// Package: shared definitions for the self-correcting twisted-ring counter.
// Assumes a fixed 4-stage ring; the repair equations are specific to it.
package jc_pkg;

    localparam int JC_W = 4;

    typedef enum logic {
        FIX_FEEDBACK = 1'b0,
        FIX_LOAD     = 1'b1
    } fix_mode_e;

    // True when the pattern is a thermometer of ones or of zeros from bit 0.
    function automatic logic jc_is_valid(input logic [JC_W-1:0] v);
        logic [JC_W-1:0] inv;
        inv = ~v;
        return ((v & (v + 4'd1)) == '0) || ((inv & (inv + 4'd1)) == '0);
    endfunction

endpackage

// File: rtl/jc_feedback.sv
// Module: next-state logic of the ring. One of two repair schemes is
// chosen at elaboration. Assumes bit 0 is the first stage and bit 3 the last.
module jc_feedback #(
    parameter jc_pkg::fix_mode_e FIX_MODE = jc_pkg::FIX_FEEDBACK,
    parameter int                W        = jc_pkg::JC_W
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);

    localparam int TOP = W - 1;

    generate
        if (FIX_MODE == jc_pkg::FIX_FEEDBACK) begin : g_fb
            logic serial_in;
            // Purpose: repaired serial input that steers stray patterns home.
            always_comb begin
                serial_in = ~cur[TOP] | (~cur[TOP-1] & cur[1]);
                nxt       = {cur[TOP-1:0], serial_in};
            end
        end else begin : g_ld
            logic load_hit;
            // Purpose: replace the shift with a fixed load on a 0xx0 match.
            always_comb begin
                load_hit = ~cur[TOP] & ~cur[0];
                if (load_hit) begin
                    nxt = {{(W-1){1'b0}}, 1'b1};
                end else begin
                    nxt = {cur[TOP-1:0], ~cur[TOP]};
                end
            end
        end
    endgenerate

endmodule

// File: rtl/jc_stage_reg.sv
// Module: state register of the ring with synchronous active-low reset
// and hold. Assumes the reset value is a legal W-bit constant.
module jc_stage_reg #(
    parameter int           W         = jc_pkg::JC_W,
    parameter logic [W-1:0] RST_STATE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Purpose: reset to the chosen pattern, else load d when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_STATE;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/jc_selfcorr_counter.sv
// Module: top level of the 4-stage self-correcting twisted-ring counter.
// Assumes a free-running clock. Reset is sampled synchronously, active low.
module jc_selfcorr_counter #(
    parameter jc_pkg::fix_mode_e FIX_MODE  = jc_pkg::FIX_FEEDBACK,
    parameter logic [3:0]        RST_STATE = 4'b0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    output logic [3:0] cnt_q
);

    localparam int W      = jc_pkg::JC_W;
    localparam int BOUND  = 2 * W;

    logic [W-1:0] nxt_state;

    jc_feedback #(.FIX_MODE(FIX_MODE), .W(W)) u_fb (
        .cur (cnt_q),
        .nxt (nxt_state)
    );

    jc_stage_reg #(.W(W), .RST_STATE(RST_STATE)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .d     (nxt_state),
        .q     (cnt_q)
    );

    // Purpose: count enabled clocks spent off the cycle, for the bound check.
    logic [W:0] stray_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stray_cnt <= '0;
        end else if (jc_pkg::jc_is_valid(cnt_q)) begin
            stray_cnt <= '0;
        end else if (cnt_en && stray_cnt != '1) begin
            stray_cnt <= stray_cnt + 1'b1;
        end
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        !rst_n |=> cnt_q == RST_STATE);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(cnt_q));

    assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && jc_pkg::jc_is_valid(cnt_q))
        |=> cnt_q == {$past(cnt_q[2:0]), ~$past(cnt_q[3])});

    assert_stay_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        jc_pkg::jc_is_valid(cnt_q) |=> jc_pkg::jc_is_valid(cnt_q));

    assert_bounded_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stray_cnt <= (W+1)'(BOUND));

    generate
        if (FIX_MODE == jc_pkg::FIX_LOAD) begin : g_ld_chk
            assert_match_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_en && !cnt_q[3] && !cnt_q[0]) |=> cnt_q == 4'b0001);
        end
    endgenerate

endmodule

// File: tb/jc_selfcorr_counter_tb.sv
// Bench: 32 instances, one per scheme and starting pattern, on one shared
// random enable. Each instance is compared with a reference model.
module jc_selfcorr_counter_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b0;
    logic [3:0] q_out [2][16];

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk; // 50 MHz

    for (genvar s = 0; s < 2; s++) begin : g_s
        for (genvar p = 0; p < 16; p++) begin : g_p
            logic [3:0] qq;
            jc_selfcorr_counter #(
                .FIX_MODE  (s == 0 ? jc_pkg::FIX_FEEDBACK : jc_pkg::FIX_LOAD),
                .RST_STATE (4'(p))
            ) u_dut (
                .clk    (clk),
                .rst_n  (rst_n),
                .cnt_en (cnt_en),
                .cnt_q  (qq)
            );
            assign q_out[s][p] = qq;
        end
    end

    // Successor on the proper cycle, from R2; valid flag returned separately.
    function automatic logic on_cycle(input logic [3:0] v);
        case (v)
            4'h0, 4'h1, 4'h3, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] cycle_next(input logic [3:0] v);
        case (v)
            4'h0: return 4'h1;
            4'h1: return 4'h3;
            4'h3: return 4'h7;
            4'h7: return 4'hF;
            4'hF: return 4'hE;
            4'hE: return 4'hC;
            4'hC: return 4'h8;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [3:0] model_next(input int s, input logic [3:0] v, input logic en);
        if (!en) return v;
        if (on_cycle(v)) return cycle_next(v);
        if (s == 0) return {v[2:0], (~v[3]) | ((~v[2]) & v[1])};
        if (!v[3] && !v[0]) return 4'b0001;
        return {v[2:0], ~v[3]};
    endfunction

    function automatic string req_tag(input int s, input logic [3:0] v, input logic en);
        if (!en) return "R3";
        if (on_cycle(v)) return "R2";
        if (s == 0) return "R4";
        if (!v[3] && !v[0]) return "R5";
        return "R6";
    endfunction

    logic [3:0] prev [2][16];
    int steps [2][16];
    bit entered [2][16];

    task automatic check_eq(input string tag, input logic [3:0] act, input logic [3:0] exp,
                            input int s, input int p);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s s=%0d p=%0d cyc=%0d actual=%h expected=%h", tag, s, p, cyc, act, exp);
        end
    endtask

    // Check R1 for every instance after a reset edge.
    task automatic check_reset();
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 16; p++) begin
                check_eq("R1", q_out[s][p], 4'(p), s, p);
                steps[s][p] = 0;
                entered[s][p] = on_cycle(4'(p));
            end
    endtask

    // One clock: drive en at negedge, check at next negedge.
    task automatic step(input logic en);
        cnt_en = en;
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 16; p++) prev[s][p] = q_out[s][p];
        @(negedge clk);
        cyc++;
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 16; p++) begin
                check_eq(req_tag(s, prev[s][p], en), q_out[s][p],
                         model_next(s, prev[s][p], en), s, p);
                if (en && !on_cycle(prev[s][p])) steps[s][p]++;
                if (on_cycle(q_out[s][p])) entered[s][p] = 1'b1;
                checks++;
                if (!entered[s][p] && steps[s][p] > 8) begin
                    failures++;
                    $display("FAIL R7 s=%0d p=%0d actual=%0d steps expected<=8", s, p, steps[s][p]);
                    entered[s][p] = 1'b1;
                end
                checks++;
                if (entered[s][p] && !on_cycle(q_out[s][p])) begin
                    failures++;
                    $display("FAIL R7 s=%0d p=%0d left cycle actual=%h expected=on-cycle", s, p, q_out[s][p]);
                end
            end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        cnt_en = 1'b1;
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        // Directed: hold every pattern, including strays (R3).
        repeat (3) step(1'b0);
        // Directed: a run of enabled clocks covers R4/R5/R6 first steps.
        repeat (4) step(1'b1);
        // Random enable, roughly 3 in 4 high.
        for (int i = 0; i < 150; i++) step(($urandom % 4) != 0);
        // Second reset while enabled: reset wins (R1).
        cnt_en = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) step(($urandom % 3) != 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule